// File: doc/BRIEF.md
# Segment Access Verification Unit

This sequential unit answers one question about a 16-bit segment selector: may the current privilege level read, or write, the segment it names? A start pulse carries the selector, the three-bit reg field of the verify instruction (4 asks for read access, 5 asks for write access), and the current privilege level. The unit also takes the base and limit of the global and local descriptor tables. It returns a one-cycle done pulse and a single flag, which is 1 when the access is allowed and 0 otherwise.

The checks run in a fixed order. A null selector, or a selector whose 8-byte descriptor does not fit inside the chosen table, fails at once. In that case the unit reads no memory. Otherwise it fetches the descriptor as two 32-bit reads over a request/response port, then checks three things in turn: the descriptor kind, privilege, and permission. The unit never faults. Every failing check simply clears the flag.

Selector layout: bits 1:0 hold the requested privilege (RPL), bit 2 selects the table (0 for global, 1 for local), and bits 15:3 hold the index. The descriptor starts at byte offset index × 8. The access byte is bits 15:8 of the second 32-bit word, and its fields are:
- bits 6:5: descriptor privilege (DPL)
- bit 4: code/data indicator, where 0 means a system segment or gate
- bit 3: set for code
- bit 2 of a code segment: conforming
- bit 1 of a code segment: readable
- bit 1 of a data segment: writable

Top module: `seg_verify_unit`

## Requirements
- R1: A selector with bits 15:2 all zero is null. It gives done with flag 0 and issues no memory request.
- R2: The table is chosen by selector bit 2, and the check fails when (index × 8 + 7) is greater than that table's limit. A failing check gives flag 0 with no memory request. A descriptor ending exactly at the limit is fetched.
- R3: A descriptor whose access-byte bit 4 is 0 gives flag 0.
- R4: Unless the segment is conforming code, the flag is 0 when DPL is numerically less than the privilege level or less than the selector's RPL.
- R5: A conforming code segment (access bits 3 and 2 both set) passes regardless of DPL, privilege level or RPL.
- R6: Read verification (reg field 4) passes for any data segment and for code with bit 1 set. Write verification (reg field 5) passes only for data with bit 1 set and never for code.
- R7: The descriptor is fetched in two requests: the first at base + index × 8, the second at that address + 4. Each request holds valid and a stable address until ready. The access byte is taken from bits 15:8 of the second response.
- R8: A start while the reg field is neither 4 nor 5 is ignored. No done pulse follows, no request is issued, and the flag is unchanged.
- R9: After reset, done, flag and request valid are all 0. Done is high for exactly one cycle. The flag changes only in a cycle where done is high and otherwise keeps its value.
- R10: When the null check or the bounds check fails, done rises in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a verification; ignored while one is in progress |
| sel | input | 16 | Segment selector to verify |
| verify_reg | input | 3 | Reg field of the instruction: 4 for read, 5 for write |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | AW | Global table base address |
| gdt_limit | input | LW | Global table limit in bytes |
| ldt_base | input | AW | Local table base address |
| ldt_limit | input | LW | Local table limit in bytes |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Byte address of the 32-bit word requested |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| zf | output | 1 | Verification result flag |

## Verification
The bench builds the unit with a 32-bit address and a 16-bit limit. With a 16-bit limit the table boundaries are small and explicit: a local table limit of 31 puts index 3 exactly on the edge and index 4 one past it. The memory model stalls ready on alternate cycles, so held requests are exercised. Its first word carries a misleading byte at bits 15:8, so taking the access byte from the wrong word changes results.

// File: rtl/seg_verify_unit.sv
module seg_verify_unit #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   sel,
  input  logic [2:0]    verify_reg,
  input  logic [1:0]    cpl,
  input  logic [AW-1:0] gdt_base,
  input  logic [LW-1:0] gdt_limit,
  input  logic [AW-1:0] ldt_base,
  input  logic [LW-1:0] ldt_limit,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  output logic          done,
  output logic          zf
);
  localparam int CW = (LW > 16) ? LW : 16;

  typedef enum logic [2:0] {S_IDLE, S_REQ0, S_RSP0, S_REQ1, S_RSP1} st_t;
  st_t st;

  logic [1:0]    rpl_q, cpl_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;

  wire busy     = (st != S_IDLE);
  wire mode_ok  = (verify_reg == 3'd4) || (verify_reg == 3'd5);
  wire go       = start && !busy && mode_ok;
  wire is_null  = (sel[15:2] == 14'd0);
  wire [LW-1:0] lim  = sel[2] ? ldt_limit : gdt_limit;
  wire [AW-1:0] base = sel[2] ? ldt_base  : gdt_base;
  wire out_rng  = CW'({sel[15:3], 3'b111}) > CW'(lim);
  wire early_no = is_null || out_rng;

  wire [7:0] acc   = mem_rsp_data[15:8];
  wire [1:0] dpl   = acc[6:5];
  wire       codes = acc[3];
  wire       conf  = codes && acc[2];
  wire       priv  = conf || ((dpl >= cpl_q) && (dpl >= rpl_q));
  wire       perm  = wr_q ? (!codes && acc[1]) : (!codes || acc[1]);
  wire       pass  = acc[4] && priv && perm;
  wire       unused_bits = ^{mem_rsp_data[31:16], mem_rsp_data[7:0], acc[7]};

  assign mem_req_valid = (st == S_REQ0) || (st == S_REQ1);
  assign mem_req_addr  = (st == S_REQ1) ? addr_q + AW'(4) : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      zf     <= 1'b0;
      rpl_q  <= 2'd0;
      cpl_q  <= 2'd0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          rpl_q  <= sel[1:0];
          cpl_q  <= cpl;
          wr_q   <= verify_reg[0];
          addr_q <= base + AW'({sel[15:3], 3'b000});
          if (early_no) begin
            done <= 1'b1;
            zf   <= 1'b0;
          end else begin
            st <= S_REQ0;
          end
        end
        S_REQ0: if (mem_req_ready) st <= S_RSP0;
        S_RSP0: if (mem_rsp_valid) st <= S_REQ1;
        S_REQ1: if (mem_req_ready) st <= S_RSP1;
        S_RSP1: if (mem_rsp_valid) begin
          st   <= S_IDLE;
          done <= 1'b1;
          zf   <= pass;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module seg_verify_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    verify_reg,
  input logic [15:0]   sel,
  input logic          busy,
  input logic          done,
  input logic          zf,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  zf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(zf));
  // R1
  null_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (verify_reg == 3'd4 || verify_reg == 3'd5) && sel[15:2] == 14'd0
    |=> done && !zf && !req_valid);
  // R8
  bad_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !(verify_reg == 3'd4 || verify_reg == 3'd5) |=> !done && !req_valid);
endmodule

bind seg_verify_unit seg_verify_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .verify_reg(verify_reg), .sel(sel),
  .busy(busy), .done(done), .zf(zf), .req_valid(mem_req_valid),
  .req_ready(mem_req_ready), .req_addr(mem_req_addr)
);

// File: tb/sim_seg_verify_unit.sv
module sim_seg_verify_unit;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam logic [AW-1:0] GB = 32'h0000_1000;
  localparam logic [AW-1:0] LB = 32'h0000_8000;
  localparam logic [LW-1:0] GL = 16'h003F;
  localparam logic [LW-1:0] LL = 16'h001F;
  localparam int NV = 16;

  // {sel, access byte, reg field, cpl, expected flag, expect fetch}
  localparam logic [30:0] VEC [NV] = '{
    {16'h0000, 8'h92, 3'd4, 2'd0, 1'b0, 1'b0},  // R1 null
    {16'h0003, 8'h92, 3'd4, 2'd0, 1'b0, 1'b0},  // R1 null with rpl
    {16'h0040, 8'h92, 3'd4, 2'd0, 1'b0, 1'b0},  // R2 global past limit
    {16'h0024, 8'hF2, 3'd5, 2'd3, 1'b0, 1'b0},  // R2 local past limit
    {16'h001F, 8'hF2, 3'd5, 2'd3, 1'b1, 1'b1},  // R2 local at limit, writable
    {16'h0008, 8'h89, 3'd4, 2'd0, 1'b0, 1'b1},  // R3 system
    {16'h0008, 8'h92, 3'd4, 2'd3, 1'b0, 1'b1},  // R4 dpl < cpl
    {16'h000B, 8'h92, 3'd4, 2'd0, 1'b0, 1'b1},  // R4 dpl < rpl
    {16'h000A, 8'hD2, 3'd4, 2'd2, 1'b1, 1'b1},  // R4 dpl equal
    {16'h0013, 8'h9E, 3'd4, 2'd3, 1'b1, 1'b1},  // R5 conforming
    {16'h0010, 8'h9C, 3'd4, 2'd0, 1'b0, 1'b1},  // R6 conforming not readable
    {16'h0013, 8'hFA, 3'd4, 2'd3, 1'b1, 1'b1},  // R6 code readable
    {16'h0013, 8'hFA, 3'd5, 2'd3, 1'b0, 1'b1},  // R6 code write
    {16'h0038, 8'hF0, 3'd5, 2'd3, 1'b0, 1'b1},  // R6 data read-only write
    {16'h0038, 8'hF0, 3'd4, 2'd3, 1'b1, 1'b1},  // R6 data read
    {16'h0013, 8'hF8, 3'd4, 2'd3, 1'b0, 1'b1}   // R6 code not readable
  };
  string TAG [NV] = '{"R1","R1","R2","R2","R2","R3","R4","R4","R4","R5",
                      "R6","R6","R6","R6","R6","R6"};

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] sel = '0;
  logic [2:0] verify_reg = 3'd4;
  logic [1:0] cpl = '0;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0, done, zf;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_rsp_data = '0;

  int tests = 0, fails = 0, cyc = 0, nacc = 0, nrsp = 0;
  logic [AW-1:0] a_prev = '0, a_last = '0;
  logic [7:0] cur_acc = '0;

  always #2.5 clk = ~clk;

  seg_verify_unit #(.AW(AW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .verify_reg(verify_reg),
    .cpl(cpl), .gdt_base(GB), .gdt_limit(GL), .ldt_base(LB), .ldt_limit(LL),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .zf(zf));

  always @(posedge clk) begin
    cyc++;
    if (mem_req_valid && mem_req_ready) begin
      a_prev <= a_last;
      a_last <= mem_req_addr;
      nacc++;
    end
  end

  always @(negedge clk) begin
    mem_req_ready = cyc[0];
    if (nacc != nrsp) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = a_last[2] ? {16'h00CF, cur_acc, 8'h12} : 32'h0000_FFFF;
      nrsp++;
    end else begin
      mem_rsp_valid = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [15:0] s, input logic [7:0] a, input logic [2:0] r,
                         input logic [1:0] c, input logic ex, input logic fe, input string tg);
    int n0, lat;
    logic [AW-1:0] ea;
    cur_acc = a;
    n0 = nacc;
    @(negedge clk);
    start = 1; sel = s; verify_reg = r; cpl = c;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 60) begin @(negedge clk); lat++; end
    check(done, {tg, " done"}, 32'(done), 1);
    check(zf == ex, {tg, " flag"}, 32'(zf), 32'(ex));
    check((nacc - n0) == (fe ? 2 : 0), {tg, " R7 request count"}, nacc - n0, fe ? 2 : 0);
    if (fe) begin
      ea = (s[2] ? LB : GB) + AW'({s[15:3], 3'b000});
      check(a_prev == ea, "R7 first address", a_prev, ea);
      check(a_last == ea + 4, "R7 second address", a_last, ea + 4);
    end else begin
      check(lat == 1, "R10 early latency", lat, 1);
    end
  endtask

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    check(!done && !zf && !mem_req_valid, "R9 reset state", {done, zf, mem_req_valid}, 0);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      run_one(VEC[i][30:15], VEC[i][14:7], VEC[i][6:4], VEC[i][3:2], VEC[i][1], VEC[i][0], TAG[i]);

    // R9 flag holds after a pass
    run_one(16'h000A, 8'hD2, 3'd4, 2'd2, 1'b1, 1'b1, "R9");
    @(negedge clk);
    check(!done, "R9 done single cycle", 32'(done), 0);
    repeat (5) @(negedge clk);
    check(zf == 1'b1, "R9 flag hold", 32'(zf), 1);

    // R8 unsupported reg field ignored
    n0 = nacc;
    @(negedge clk);
    start = 1; sel = 16'h000A; verify_reg = 3'd6; cpl = 2'd2; cur_acc = 8'h92;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 10; k++) begin
      check(!done, "R8 no done", 32'(done), 0);
      @(negedge clk);
    end
    check(nacc == n0, "R8 no request", nacc - n0, 0);
    check(zf == 1'b1, "R8 flag unchanged", 32'(zf), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule